// File: doc/BRIEF.md
# Ultra DMA Write Burst Timing Generator

This block drives the host end of an ATA Ultra DMA data-out burst. It is clocked by the system bus clock. Every protocol interval is counted in whole bus-clock periods and read from one packed timing word. That word is captured when the burst starts. The block takes 16-bit words from a valid/ready source and places each one on the data bus. It toggles the host strobe once per word, so every strobe edge carries one word. The word period is the programmed data-valid setup count plus the programmed data-valid hold count. Throughput is therefore two bytes per word period.

A burst begins with a start pulse. The acknowledge line is asserted, and the acknowledge envelope runs before the first word is taken. The device can pause the burst by dropping its ready line. The word already on the bus still completes, and then the strobe stays put. The device may end the burst only after ready has been low for the ready-to-pause interval. The host side can also end the burst. In both cases the block enters a stop sequence: the strobe is returned to its idle level and the stop indication is held for the stop-setup interval. The acknowledge line then stays up for another acknowledge interval before the block goes idle.

Timing word fields (each phase lasts its field value plus one clock): [3:0] acknowledge, [7:4] stop setup, [15:8] ready-to-pause, [23:16] data setup, [27:24] data hold. With a 108 MHz clock, data setup and data hold fields of 1 each give a 37 ns word period, about 54 MB/s.

Top module: `udma_wr_timer`

## Requirements
- R1: Out of reset, dma_ack, wr_strobe, host_stop and in_ready are all 0. The idle strobe level is 0.
- R2: A start pulse in idle raises dma_ack at the next edge. in_ready stays 0 for acknowledge-field+1 cycles after dma_ack is first seen high.
- R3: bus_data changes only on an edge where a word is accepted (in_valid and in_ready both high). It then holds that word through the setup and hold phases.
- R4: wr_strobe toggles exactly data-setup-field+1 cycles after a new word appears on bus_data.
- R5: While words and device readiness are continuously available, successive strobe toggles are (setup field+1)+(hold field+1) cycles apart. This holds for the timing words 0x4071152, 0x2050d52, 0x2030a52, 0x1020a52 and 0x1010a52.
- R6: While dev_rdy is 0, no new word is accepted. The word already in its setup phase still gets its strobe toggle. After that the strobe and data stay stable until dev_rdy returns.
- R7: dev_term is honoured only while dev_rdy is 0 and waiting, and only once dev_rdy has been low there for ready-to-pause-field+1 cycles. host_stop rises at the following edge.
- R8: In the stop sequence host_stop is 1 and wr_strobe is 0. dma_ack falls (stop-setup-field+1)+(acknowledge-field+1) cycles after host_stop rises, and host_stop falls with it.
- R9: host_end takes priority over a pending word. While host_end is 1, in_ready is 0. At the end of the current word's hold phase the stop sequence begins.
- R10: The timing word is captured at start. Changing the timing input during a burst has no effect on any interval.
- R11: A start pulse while dma_ack is high is ignored and does not begin another burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a burst (honoured in idle only) |
| host_end | input | 1 | Host request to end the burst |
| timing | input | 28 | Packed phase counts |
| in_data | input | 16 | Source word |
| in_valid | input | 1 | Source word valid |
| in_ready | output | 1 | Word accepted at this edge when valid |
| dev_rdy | input | 1 | Device ready to receive (0 = pause) |
| dev_term | input | 1 | Device request to terminate |
| dma_ack | output | 1 | DMA acknowledge to device, active high |
| host_stop | output | 1 | Host stop indication |
| wr_strobe | output | 1 | Host strobe; each edge transfers a word |
| bus_data | output | 16 | Data bus toward the device |

## Verification
The end of a word's hold phase is the cycle where two functions collide: a new word may be accepted, or the stop sequence may begin. The bench raises host_end during a hold phase while the source keeps a word valid. It then checks three things: in_ready never goes high, the accepted-word count stays the same, and host_stop appears exactly one hold interval later. Device termination is held asserted from the first paused cycle, so the cycle where it is first honoured can be counted against the ready-to-pause field.

// File: rtl/udma_wr_timer.sv
module udma_wr_timer #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          host_end,
  input  logic [27:0]   timing,
  input  logic [DW-1:0] in_data,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          dev_rdy,
  input  logic          dev_term,
  output logic          dma_ack,
  output logic          host_stop,
  output logic          wr_strobe,
  output logic [DW-1:0] bus_data
);

  typedef enum logic [2:0] {S_IDLE, S_ACK, S_WAIT, S_SETUP, S_HOLD, S_STOP, S_REL} st_t;

  st_t         st;
  logic [27:0] tm_q;
  logic [7:0]  cnt;
  logic [8:0]  pcnt;
  logic        phase_end;

  wire [3:0] f_ack = tm_q[3:0];
  wire [3:0] f_ss  = tm_q[7:4];
  wire [7:0] f_rp  = tm_q[15:8];
  wire [7:0] f_dvs = tm_q[23:16];
  wire [3:0] f_dvh = tm_q[27:24];
  wire [8:0] p_lim = {1'b0, f_rp} + 9'd1;

  always_comb begin
    case (st)
      S_ACK, S_REL: phase_end = (cnt == {4'd0, f_ack});
      S_SETUP:      phase_end = (cnt == f_dvs);
      S_HOLD:       phase_end = (cnt == {4'd0, f_dvh});
      S_STOP:       phase_end = (cnt == {4'd0, f_ss});
      default:      phase_end = 1'b0;
    endcase
  end

  wire pick    = (st == S_WAIT) || (st == S_HOLD && phase_end);
  wire end_go  = pick && host_end;
  wire term_go = (st == S_WAIT) && !dev_rdy && dev_term && (pcnt == p_lim);
  wire take    = in_ready && in_valid;

  assign in_ready  = pick && dev_rdy && !host_end;
  assign dma_ack   = (st != S_IDLE);
  assign host_stop = (st == S_STOP) || (st == S_REL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      tm_q      <= '0;
      cnt       <= '0;
      pcnt      <= '0;
      wr_strobe <= 1'b0;
      bus_data  <= '0;
    end else begin
      cnt <= cnt + 8'd1;
      if (st == S_WAIT && !dev_rdy) begin
        if (pcnt != p_lim) pcnt <= pcnt + 9'd1;
      end else begin
        pcnt <= '0;
      end
      case (st)
        S_IDLE: begin
          cnt <= '0;
          if (start) begin
            tm_q <= timing;
            st   <= S_ACK;
          end
        end
        S_ACK: if (phase_end) begin
          cnt <= '0;
          st  <= S_WAIT;
        end
        S_WAIT: begin
          cnt <= '0;
          if (end_go || term_go) begin
            wr_strobe <= 1'b0;
            st        <= S_STOP;
          end else if (take) begin
            bus_data <= in_data;
            st       <= S_SETUP;
          end
        end
        S_SETUP: if (phase_end) begin
          cnt       <= '0;
          wr_strobe <= ~wr_strobe;
          st        <= S_HOLD;
        end
        S_HOLD: if (phase_end) begin
          cnt <= '0;
          if (end_go) begin
            wr_strobe <= 1'b0;
            st        <= S_STOP;
          end else if (take) begin
            bus_data <= in_data;
            st       <= S_SETUP;
          end else begin
            st <= S_WAIT;
          end
        end
        S_STOP: if (phase_end) begin
          cnt <= '0;
          st  <= S_REL;
        end
        S_REL: if (phase_end) begin
          cnt <= '0;
          st  <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/udma_wr_timer_chk.sv
module udma_wr_timer_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          host_end,
  input logic          in_valid,
  input logic          in_ready,
  input logic          dev_rdy,
  input logic          dma_ack,
  input logic          host_stop,
  input logic          wr_strobe,
  input logic [DW-1:0] bus_data
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_ack |-> (!wr_strobe && !host_stop && !in_ready));

  p_start_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !dma_ack) |=> (dma_ack && !in_ready));

  p_data_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bus_data) |-> $past(in_ready && in_valid));

  p_strobe_in_burst_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wr_strobe) |-> $past(dma_ack));

  p_pause_no_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> dev_rdy);

  p_stop_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    host_stop |-> (dma_ack && !wr_strobe && !in_ready));

  p_end_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    host_end |-> !in_ready);

endmodule

bind udma_wr_timer udma_wr_timer_chk #(.DW(DW)) u_chk (.*);

// File: tb/sim_udma_wr_timer.sv
module sim_udma_wr_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        host_end = 1'b0;
  logic [27:0] timing = '0;
  logic [15:0] in_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        dev_rdy = 1'b1;
  logic        dev_term = 1'b0;
  logic        dma_ack;
  logic        host_stop;
  logic        wr_strobe;
  logic [15:0] bus_data;

  always #10 clk = ~clk;

  udma_wr_timer u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .host_end(host_end),
    .timing(timing), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .dev_rdy(dev_rdy), .dev_term(dev_term),
    .dma_ack(dma_ack), .host_stop(host_stop), .wr_strobe(wr_strobe),
    .bus_data(bus_data)
  );

  int ncmp = 0, nbad = 0;
  int cyc = 0, ntog = 0, dchg = 0, n_acc = 0;
  int tog_cyc[32];
  int tog_dcyc[32];
  logic [15:0] tog_dat[32];
  logic [15:0] last_d = '0;
  logic        last_s = 1'b0;
  logic        hs = 1'b0;
  logic [15:0] base = '0;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (bus_data !== last_d) begin
      dchg   = cyc;
      last_d = bus_data;
    end
    if (wr_strobe !== last_s) begin
      if (ntog < 32) begin
        tog_cyc[ntog]  = cyc;
        tog_dat[ntog]  = bus_data;
        tog_dcyc[ntog] = cyc - dchg;
      end
      ntog   = ntog + 1;
      last_s = wr_strobe;
    end
  end

  always @(negedge clk) begin
    #2 hs = in_valid && in_ready;
  end

  always @(posedge clk) begin
    #1 if (hs) begin
      n_acc   = n_acc + 1;
      in_data = base + 16'(n_acc);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    ncmp++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic fresh(input logic [15:0] b);
    base    = b;
    n_acc   = 0;
    in_data = b;
    ntog    = 0;
  endtask

  task automatic begin_burst(input logic [27:0] t);
    @(negedge clk);
    timing = t;
    start  = 1'b1;
    @(negedge clk);
    start  = 1'b0;
    timing = 28'h0;
  endtask

  task automatic end_burst();
    int g = 0;
    @(negedge clk);
    host_end = 1'b1;
    while (dma_ack && g < 500) begin
      @(negedge clk);
      g++;
    end
    host_end = 1'b0;
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    #1;
    chk(dma_ack == 1'b0 && host_stop == 1'b0, "R1 in reset", {dma_ack, host_stop}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    in_valid = 1'b1;
    @(negedge clk);
    #1;
    chk(dma_ack == 1'b0, "R1 dma_ack", dma_ack, 0);
    chk(wr_strobe == 1'b0, "R1 wr_strobe", wr_strobe, 0);
    chk(host_stop == 1'b0, "R1 host_stop", host_stop, 0);
    chk(in_ready == 1'b0, "R1 in_ready", in_ready, 0);
    in_valid = 1'b0;
  endtask

  task automatic t_ack();
    int c = 0;
    fresh(16'h0100);
    in_valid = 1'b1;
    dev_rdy  = 1'b1;
    begin_burst(28'h1010a53);
    chk(dma_ack == 1'b1, "R2 ack rise", dma_ack, 1);
    while (!in_ready && c < 50) begin
      c++;
      @(negedge clk);
    end
    chk(c == 4, "R2 envelope", c, 4);
    end_burst();
  endtask

  task automatic t_stream(input logic [27:0] t, input logic [15:0] b);
    int dvs = int'(t[23:16]);
    int dvh = int'(t[27:24]);
    int g = 0;
    fresh(b);
    in_valid = 1'b1;
    dev_rdy  = 1'b1;
    begin_burst(t);
    while (ntog < 5 && g < 1000) begin
      @(negedge clk);
      g++;
    end
    in_valid = 1'b0;
    end_burst();
    for (int k = 0; k < 5; k++) begin
      chk(tog_dat[k] == b + 16'(k), "R3 word order", tog_dat[k], b + k);
      chk(tog_dcyc[k] == dvs + 1, "R4 setup", tog_dcyc[k], dvs + 1);
    end
    for (int k = 1; k < 5; k++) begin
      // R10: timing input was zeroed right after start
      chk(tog_cyc[k] - tog_cyc[k-1] == dvs + dvh + 2, "R5 R10 period",
          tog_cyc[k] - tog_cyc[k-1], dvs + dvh + 2);
    end
  endtask

  task automatic t_pause();
    int g = 0;
    bit rdy_seen = 0;
    fresh(16'h2000);
    in_valid = 1'b1;
    dev_rdy  = 1'b1;
    begin_burst(28'h3030a52);
    while (n_acc < 1 && g < 100) begin
      @(negedge clk);
      g++;
    end
    dev_rdy = 1'b0;
    for (int i = 0; i < 40; i++) begin
      #1;
      if (in_ready) rdy_seen = 1;
      @(negedge clk);
    end
    chk(!rdy_seen, "R6 no accept", rdy_seen, 0);
    chk(ntog == 1, "R6 word finished", ntog, 1);
    chk(bus_data == 16'h2000, "R6 data held", bus_data, 16'h2000);
    dev_rdy = 1'b1;
    g = 0;
    while (ntog < 2 && g < 100) begin
      @(negedge clk);
      g++;
    end
    chk(tog_dat[1] == 16'h2001, "R6 resume", tog_dat[1], 16'h2001);
    in_valid = 1'b0;
    end_burst();
  endtask

  task automatic t_term();
    int g = 0, c = 0, d = 0;
    bit stop_ok = 1;
    fresh(16'h3000);
    in_valid = 1'b1;
    dev_rdy  = 1'b1;
    begin_burst(28'h1010a52);
    while (n_acc < 3 && g < 100) begin
      @(negedge clk);
      g++;
    end
    in_valid = 1'b0;
    repeat (10) @(negedge clk);
    chk(wr_strobe == 1'b1, "R8 strobe before stop", wr_strobe, 1);
    dev_rdy  = 1'b0;
    dev_term = 1'b1;
    while (!host_stop && c < 100) begin
      @(negedge clk);
      c++;
    end
    chk(c == 12, "R7 pause before term", c, 12);
    chk(wr_strobe == 1'b0, "R8 strobe idle", wr_strobe, 0);
    while (dma_ack && d < 100) begin
      @(negedge clk);
      d++;
      if (d == 3) begin
        start  = 1'b1;
        timing = 28'h4071152;
      end
      if (d == 4) start = 1'b0;
      if (dma_ack && !host_stop) stop_ok = 0;
    end
    chk(d == 9, "R8 release delay", d, 9);
    chk(stop_ok && !host_stop, "R8 host_stop span", stop_ok, 1);
    dev_term = 1'b0;
    dev_rdy  = 1'b1;
    g = 0;
    for (int i = 0; i < 6; i++) begin
      if (dma_ack) g++;
      @(negedge clk);
    end
    chk(g == 0, "R11 start ignored", g, 0);
  endtask

  task automatic t_end_collide();
    int g = 0, e = 0, a;
    bit rdy_seen = 0;
    fresh(16'h4000);
    in_valid = 1'b1;
    dev_rdy  = 1'b1;
    begin_burst(28'h2030a52);
    while (wr_strobe !== 1'b1 && g < 200) begin @(negedge clk); g++; end
    while (wr_strobe !== 1'b0 && g < 200) begin @(negedge clk); g++; end
    host_end = 1'b1;
    a = n_acc;
    while (!host_stop && e < 100) begin
      #1;
      if (in_ready) rdy_seen = 1;
      @(negedge clk);
      e++;
    end
    chk(e == 3, "R9 stop after hold", e, 3);
    while (dma_ack && g < 400) begin
      #1;
      if (in_ready) rdy_seen = 1;
      @(negedge clk);
      g++;
    end
    chk(!rdy_seen, "R9 in_ready low", rdy_seen, 0);
    chk(n_acc == a, "R9 no extra word", n_acc, a);
    host_end = 1'b0;
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_ack();
    t_stream(28'h4071152, 16'h1000);
    t_stream(28'h2050d52, 16'h1100);
    t_stream(28'h2030a52, 16'h1200);
    t_stream(28'h1020a52, 16'h1300);
    t_stream(28'h1010a52, 16'h1400);
    t_pause();
    t_term();
    t_end_collide();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
    $finish;
  end

  initial begin
    repeat (150000) @(negedge clk);
    ncmp++;
    nbad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
    $finish;
  end
endmodule